// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst. A controller presents a starting column, a 12-bit mode word and a read/write flag together with a one-cycle start pulse. The block latches the start column and the decoded settings. From the next cycle it emits one column address per clock with a valid flag, and it raises a last flag on the final beat.

Beats can follow sequential order or interleaved order. Both orders stay inside an aligned block whose size is the burst length. A full-page burst walks the whole row and runs until the controller pulses stop. A write can be forced to a single-location access. Mode words with illegal or reserved fields are flagged and produce no beats. The decoded read latency is offered on an output for the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: Mode bits [2:0] select the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. last is high only on the final beat of a bounded burst, and valid falls on the cycle after last.
- R2: With mode bit 3 = 0, beat i carries the low log2(BL) bits of (start + i) modulo BL. A 4-beat burst from column 2 yields 2,3,0,1.
- R3: With mode bit 3 = 1, beat i carries the start column's low bits XOR i. An 8-beat burst from column 5 yields 5,4,7,6,1,0,3,2.
- R4: The column bits above the low log2(BL) bits equal those of the start column on every beat.
- R5: A 1-beat burst outputs the full start column and sets last on that beat, whatever the value of bit 3.
- R6: A full-page burst steps sequentially through 2^PAGE_W columns from the start column and wraps at the row end. It never raises last. When stop is high at a clock edge, valid is low from that edge onward.
- R7: Mode bits [6:4] give the read latency on rd_latency: 001 gives 1, 010 gives 2, 011 gives 3. After an erroneous start, rd_latency reads 0.
- R8: When mode bit 9 is 1 and is_write is high at start, the burst has one beat. A read with the same mode word keeps the programmed length.
- R9: mode_error rises after a start whose mode word has any of these: length code 100, 101 or 110; length 111 with bit 3 set; latency code 000 or 1xx; bits [8:7] not 00; bits [11:10] not 00. No valid beat follows such a start, and mode_error stays high until the next start.
- R10: A start during an active burst drops the rest of that burst. The new burst's first beat appears on the next cycle.
- R11: After reset, valid, last and mode_error are low and stay low until a start arrives.
- R12: The first beat appears on the clock edge that samples start, so it is visible one cycle after start is driven. start takes priority over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; latches start_col, mode_word and is_write |
| start_col | input | COL_W | Starting column |
| mode_word | input | 12 | Programmed mode word |
| is_write | input | 1 | High when the burst is a write |
| stop | input | 1 | Ends the active burst at this edge |
| col_out | output | COL_W | Column for the current beat |
| valid | output | 1 | col_out carries a beat |
| last | output | 1 | Current beat is the final one |
| mode_error | output | 1 | Last start carried an illegal mode word |
| rd_latency | output | 2 | Decoded read latency, 0 when in error |

## Verification
Sequential bursts start inside a block, not only at its base, so that wrap and plain increment give different results. Interleaved bursts use odd and mid-block starts, where XOR and addition diverge. Start columns with nonzero upper bits expose any carry that leaks out of the block. A full-page run longer than the row length separates a row-end wrap from a carry into the bank bits. Each reserved field is sent on its own to show that every error source is decoded, and a start during a burst plus a stop during a full-page burst show that both ways of cutting a burst short take effect on the right edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd4
    } burst_len_e;

    typedef struct packed {
        burst_len_e len;
        logic       inter;
        logic [1:0] lat;
        logic       wr_single;
        logic       err;
    } mode_dec_t;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import burst_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output mode_dec_t         dec
);

    logic len_bad;
    logic lat_bad;
    logic op_bad;

    always_comb begin
        dec      = '0;
        dec.len  = LEN_1;
        len_bad  = 1'b0;
        lat_bad  = 1'b0;

        unique case (mode_word[2:0])
            3'b000:  dec.len = LEN_1;
            3'b001:  dec.len = LEN_2;
            3'b010:  dec.len = LEN_4;
            3'b011:  dec.len = LEN_8;
            3'b111: begin
                dec.len = LEN_PAGE;
                len_bad = mode_word[3];
            end
            default: len_bad = 1'b1;
        endcase

        unique case (mode_word[6:4])
            3'b001:  dec.lat = 2'd1;
            3'b010:  dec.lat = 2'd2;
            3'b011:  dec.lat = 2'd3;
            default: begin
                dec.lat = 2'd0;
                lat_bad = 1'b1;
            end
        endcase

        op_bad        = (mode_word[8:7] != 2'b00) || (mode_word[11:10] != 2'b00);
        dec.inter     = mode_word[3];
        dec.wr_single = mode_word[9];
        dec.err       = len_bad || lat_bad || op_bad;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             inter,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        seq_col = (base & ~mask) | ((base + beat) & mask);
        xor_col = base ^ (beat & mask);
        col     = inter ? xor_col : seq_col;
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              is_write,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              valid,
    output logic              last,
    output logic              mode_error,
    output logic [1:0]        rd_latency
);

    localparam logic [COL_W-1:0] PAGE_MASK = COL_W'((64'd1 << PAGE_W) - 64'd1);

    typedef struct packed {
        logic             active;
        logic             err;
        logic             inter;
        logic             full;
        logic [1:0]       lat;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
    } state_t;

    state_t     st_d;
    state_t     st_q;
    mode_dec_t  dec;
    burst_len_e eff_len;
    logic [COL_W-1:0] new_mask;
    logic       at_end;

    burst_mode_decode i_dec (
        .mode_word (mode_word),
        .dec       (dec)
    );

    always_comb begin
        eff_len = (is_write && dec.wr_single) ? LEN_1 : dec.len;
        unique case (eff_len)
            LEN_2:    new_mask = COL_W'(1);
            LEN_4:    new_mask = COL_W'(3);
            LEN_8:    new_mask = COL_W'(7);
            LEN_PAGE: new_mask = PAGE_MASK;
            default:  new_mask = '0;
        endcase

        at_end = st_q.active && !st_q.full && (st_q.beat == st_q.mask);

        st_d = st_q;
        if (start) begin
            st_d.active = !dec.err;
            st_d.err    = dec.err;
            st_d.inter  = dec.inter;
            st_d.full   = (eff_len == LEN_PAGE);
            st_d.lat    = dec.err ? 2'd0 : dec.lat;
            st_d.base   = start_col;
            st_d.mask   = new_mask;
            st_d.beat   = '0;
        end else if (st_q.active) begin
            if (stop || at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = (st_q.beat + COL_W'(1)) & st_q.mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_col_gen #(.COL_W(COL_W)) i_gen (
        .base  (st_q.base),
        .beat  (st_q.beat),
        .mask  (st_q.mask),
        .inter (st_q.inter),
        .col   (col_out)
    );

    assign valid      = st_q.active;
    assign last       = at_end;
    assign mode_error = st_q.err;
    assign rd_latency = st_q.lat;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic stop,
    input logic valid,
    input logic last,
    input logic mode_error
);

    // R1: last only marks a real beat
    a_r1_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    // R1: the burst ends after its last beat
    a_r1_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && !start) |=> !valid);

    // R9: an illegal mode yields no beats
    a_r9_error_no_beats: assert property (@(posedge clk) disable iff (!rst_n)
        mode_error |-> !valid);

    // R6: stop ends a burst at the edge that samples it
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && stop && !start) |=> !valid);

    // R12: a start leads to either beats or an error, never both
    a_r12_start_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid != mode_error));

    // R11: no beats appear without a start
    a_r11_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start) |=> !valid);

endmodule

bind burst_col_seq burst_col_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .valid      (valid),
    .last       (last),
    .mode_error (mode_error)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

    localparam int COL_W  = 10;
    localparam int PAGE_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [11:0]      mode_word = '0;
    logic             is_write = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             valid;
    logic             last;
    logic             mode_error;
    logic [1:0]       rd_latency;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .PAGE_W(PAGE_W)) i_burst_col_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .mode_word  (mode_word),
        .is_write   (is_write),
        .stop       (stop),
        .col_out    (col_out),
        .valid      (valid),
        .last       (last),
        .mode_error (mode_error),
        .rd_latency (rd_latency)
    );

    // Mode word: [2:0] length, [3] type, [6:4] latency, [9] write single
    function automatic logic [11:0] mw(input logic [2:0] len, input logic typ,
                                       input logic [2:0] lat, input logic wb);
        return {2'b00, wb, 2'b00, lat, typ, len};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a start; returns at the negedge where beat 0 is visible
    task automatic launch(input logic [11:0] m, input int col, input logic wr);
        @(negedge clk);
        start     = 1'b1;
        mode_word = m;
        start_col = COL_W'(col);
        is_write  = wr;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic beat(input string req, input int exp_col, input logic exp_last);
        check({req, " valid"}, int'(valid), 1);
        check({req, " col"}, int'(col_out), exp_col);
        check({req, " last"}, int'(last), int'(exp_last));
        @(negedge clk);
    endtask

    task automatic idle_after(input string req);
        check({req, " valid drops"}, int'(valid), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 valid after reset", int'(valid), 0);
        check("R11 last after reset", int'(last), 0);
        check("R11 mode_error after reset", int'(mode_error), 0);
        repeat (3) @(negedge clk);
        check("R11 still idle", int'(valid), 0);
    endtask

    task automatic t_seq_wrap;
        launch(mw(3'b010, 1'b0, 3'b010, 1'b0), 2, 1'b0);   // R12 beat 0 next cycle
        beat("R2 seq4", 2, 0);
        beat("R2 seq4", 3, 0);
        beat("R2 seq4", 0, 0);
        beat("R1 R2 seq4", 1, 1);
        idle_after("R1 seq4");
        launch(mw(3'b011, 1'b0, 3'b010, 1'b0), 'h2E, 1'b0);
        for (int i = 0; i < 8; i++) beat("R2 R4 seq8", 'h28 | ((6 + i) % 8), i == 7);
        idle_after("R1 seq8");
    endtask

    task automatic t_interleave;
        int exp_seq[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
        launch(mw(3'b011, 1'b1, 3'b011, 1'b0), 'h3C5, 1'b0);
        for (int i = 0; i < 8; i++) beat("R3 R4 int8", 'h3C0 | exp_seq[i], i == 7);
        idle_after("R1 int8");
        launch(mw(3'b010, 1'b1, 3'b011, 1'b0), 'h1F6, 1'b0);
        beat("R3 int4", 'h1F6, 0);
        beat("R3 int4", 'h1F7, 0);
        beat("R3 int4", 'h1F4, 0);
        beat("R3 int4", 'h1F5, 1);
        idle_after("R3 int4");
    endtask

    task automatic t_bl2_block;
        launch(mw(3'b001, 1'b0, 3'b001, 1'b0), 'h2A3, 1'b0);
        beat("R4 seq2", 'h2A3, 0);
        beat("R4 seq2", 'h2A2, 1);
        idle_after("R4 seq2");
    endtask

    task automatic t_bl1;
        launch(mw(3'b000, 1'b1, 3'b001, 1'b0), 'h155, 1'b0);
        beat("R5 bl1 type ignored", 'h155, 1);
        idle_after("R5 bl1");
    endtask

    task automatic t_full_page;
        int bad = 0;
        int nlast = 0;
        launch(mw(3'b111, 1'b0, 3'b010, 1'b0), 'h3FE, 1'b0);
        beat("R6 page", 'h3FE, 0);
        beat("R6 page", 'h3FF, 0);
        beat("R6 page wrap", 'h000, 0);
        beat("R6 page", 'h001, 0);
        check("R6 before stop", int'(valid), 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R6 stop ends burst", int'(valid), 0);
        repeat (2) @(negedge clk);
        launch(mw(3'b111, 1'b0, 3'b010, 1'b0), 'h005, 1'b0);
        for (int k = 0; k < 1100; k++) begin
            if (!valid || col_out !== COL_W'((5 + k) % 1024)) bad++;
            if (last) nlast++;
            @(negedge clk);
        end
        check("R6 long page sequence mismatches", bad, 0);
        check("R6 page never last", nlast, 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R6 stop after long run", int'(valid), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_latency;
        launch(mw(3'b000, 1'b0, 3'b001, 1'b0), 0, 1'b0);
        check("R7 latency 1", int'(rd_latency), 1);
        repeat (2) @(negedge clk);
        launch(mw(3'b000, 1'b0, 3'b010, 1'b0), 0, 1'b0);
        check("R7 latency 2", int'(rd_latency), 2);
        repeat (2) @(negedge clk);
        launch(mw(3'b000, 1'b0, 3'b011, 1'b0), 0, 1'b0);
        check("R7 latency 3", int'(rd_latency), 3);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_write_single;
        launch(mw(3'b010, 1'b0, 3'b010, 1'b1), 'h0A1, 1'b1);
        beat("R8 write single", 'h0A1, 1);
        idle_after("R8 write single");
        launch(mw(3'b010, 1'b0, 3'b010, 1'b1), 'h0A1, 1'b0);
        beat("R8 read keeps length", 'h0A1, 0);
        beat("R8 read keeps length", 'h0A2, 0);
        beat("R8 read keeps length", 'h0A3, 0);
        beat("R8 read keeps length", 'h0A0, 1);
        idle_after("R8 read");
    endtask

    task automatic t_errors;
        logic [11:0] bad_modes[8];
        bad_modes[0] = mw(3'b100, 1'b0, 3'b010, 1'b0);
        bad_modes[1] = mw(3'b101, 1'b0, 3'b010, 1'b0);
        bad_modes[2] = mw(3'b110, 1'b0, 3'b010, 1'b0);
        bad_modes[3] = mw(3'b111, 1'b1, 3'b010, 1'b0);
        bad_modes[4] = mw(3'b010, 1'b0, 3'b000, 1'b0);
        bad_modes[5] = mw(3'b010, 1'b0, 3'b100, 1'b0);
        bad_modes[6] = mw(3'b010, 1'b0, 3'b010, 1'b0) | 12'h080;
        bad_modes[7] = mw(3'b010, 1'b0, 3'b010, 1'b0) | 12'h400;
        for (int i = 0; i < 8; i++) begin
            launch(bad_modes[i], 'h10, 1'b0);
            check($sformatf("R9 error flag case %0d", i), int'(mode_error), 1);
            check($sformatf("R9 no beat case %0d", i), int'(valid), 0);
            check($sformatf("R7 latency zero case %0d", i), int'(rd_latency), 0);
            @(negedge clk);
            check($sformatf("R9 error held case %0d", i), int'(mode_error), 1);
            check($sformatf("R9 still no beat case %0d", i), int'(valid), 0);
        end
        launch(mw(3'b000, 1'b0, 3'b010, 1'b0), 'h33, 1'b0);
        check("R9 error cleared by legal start", int'(mode_error), 0);
        beat("R9 legal after error", 'h33, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_truncate;
        launch(mw(3'b011, 1'b0, 3'b010, 1'b0), 'h100, 1'b0);
        beat("R10 first burst", 'h100, 0);
        check("R10 first burst beat1", int'(col_out), 'h101);
        start     = 1'b1;
        stop      = 1'b1;                  // R12 start wins over stop
        mode_word = mw(3'b001, 1'b0, 3'b010, 1'b0);
        start_col = COL_W'('h207);
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b0;
        beat("R10 R12 new burst", 'h207, 0);
        beat("R10 new burst", 'h206, 1);
        idle_after("R10 truncated");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq_wrap();
        t_interleave();
        t_bl2_block();
        t_bl1();
        t_full_page();
        t_latency();
        t_write_single();
        t_errors();
        t_truncate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule